// File: doc/BRIEF.md
# Rectangle Fill Raster Engine

This engine paints or alters a rectangle of 8-bit pixels in a byte-addressed framebuffer. The framebuffer sits in a single-port memory that is 32 bits wide and takes per-byte write enables. A start pulse captures the operation parameters:

- destination X and Y,
- width and height in pixels,
- an 8-bit colour and an 8-bit plane mask,
- an operation code,
- the line stride in bytes.

The engine then walks the rectangle one row at a time. The first pixel of the rectangle sits at `BASE + Y*stride + X`, and every later row starts one stride further on. Each row is split into three parts: single-byte accesses until the address reaches a word boundary, full-word accesses while at least four pixels remain, and single-byte accesses for what is left over. Narrow rectangles of three pixels or fewer use single bytes only.

The operation code selects one of three functions: masked set, masked XOR, or invert. An unmasked set writes blindly. Every other function reads the destination word first and writes it back in the next cycle, using the same address and byte enables. `done` is raised when the last access has completed. It stays high until the next accepted start.

Top module: `rfill_engine`

## Requirements
- R1: The first access of a rectangle targets byte address BASE + Y*stride + X. Each later row starts exactly `stride` bytes after the previous row start. Within a row, pixels are consecutive bytes.
- R2: While the current address has nonzero low two bits and pixels remain in the row, the engine accesses one byte. The byte enable is one-hot, with the set bit at the lane equal to address bits [1:0].
- R3: A full-word access (`mem_be` = 4'b1111) happens only when the rectangle width is greater than 3, the address is word aligned and at least 4 pixels remain in the row. Any remaining pixels are then accessed singly.
- R4: Operation code 2'b00 (set) stores (colour AND mask) OR (old AND NOT mask) in every covered pixel. Colour and mask are replicated into all four byte lanes.
- R5: Operation code 2'b01 (XOR) stores old XOR (colour AND mask) in every covered pixel.
- R6: Operation codes 2'b10 and 2'b11 (invert) store the bitwise complement of the old pixel. Colour and mask have no effect.
- R7: A set with mask 8'hFF issues only writes and never reads the destination.
- R8: Every other operation issues, for each access, one read followed in the very next cycle by a write to the same word with the same byte enables. Read data is expected one cycle after the read request.
- R9: A start with width 0 or height 0 raises `done` on the clock edge that accepts it and makes no memory access.
- R10: `done` stays high until the next accepted start, and no request is made while `done` is high. A start pulse that arrives while the engine is busy is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| dst_x | input | XW | Destination X in pixels |
| dst_y | input | YW | Destination Y in lines |
| width | input | XW | Rectangle width in pixels |
| height | input | YW | Rectangle height in lines |
| colour | input | 8 | Fill colour |
| plane_mask | input | 8 | Bit mask of planes to modify |
| op | input | 2 | 00 set, 01 XOR, 1x invert |
| stride | input | AW | Line stride in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished; held until next start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench sweeps start X, width from 0 to 9, heights including 0, and strides that are not multiples of 4, so that every row begins at a different alignment. A wrong head, body or tail split changes the counts of word writes and total accesses that the bench computes for each row, and a wrong row address corrupts bytes outside the rectangle. All four operation variants are compared byte by byte against an arithmetic model over the whole memory. A design that mixes up the mask terms, or lets colour leak into invert, leaves wrong pixels. A design that skips or misorders the read leaves unpaired writes or stray reads. Zero-size starts, stray starts while busy, and the hold of `done` are checked directly at the ports.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rfill_state_e;

    localparam logic [1:0] OP_SET = 2'b00;
    localparam logic [1:0] OP_XOR = 2'b01;

    // The old pixel is needed unless this is a set that touches every plane.
    function automatic logic needs_old(input logic [1:0] op, input logic [7:0] msk);
        return (op != OP_SET) || (msk != 8'hFF);
    endfunction

endpackage

// File: rtl/rfill_chunk.sv
module rfill_chunk #(
    parameter int XW = 10
) (
    input  logic [1:0]    addr_lo,
    input  logic [XW-1:0] left,
    input  logic [XW-1:0] wid,
    output logic          is_word,
    output logic [2:0]    step,
    output logic [3:0]    be
);
    always_comb begin
        is_word = (wid > XW'(3)) && (addr_lo == 2'b00) && (left >= XW'(4));
        step    = is_word ? 3'd4 : 3'd1;
        be      = is_word ? 4'b1111 : (4'b0001 << addr_lo);
    end
endmodule

// File: rtl/rfill_lane_alu.sv
module rfill_lane_alu #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] old_word,
    input  logic [7:0]         colour,
    input  logic [7:0]         msk,
    input  logic [1:0]         op,
    output logic [8*LANES-1:0] new_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] old_px;
        logic [7:0] new_px;
        assign old_px = old_word[8*g +: 8];
        always_comb begin
            unique case (op)
                rfill_pkg::OP_SET: new_px = (colour & msk) | (old_px & ~msk);
                rfill_pkg::OP_XOR: new_px = old_px ^ (colour & msk);
                default:           new_px = ~old_px;
            endcase
        end
        assign new_word[8*g +: 8] = new_px;
    end
endmodule

// File: rtl/rfill_engine.sv
module rfill_engine #(
    parameter int          AW   = 16,
    parameter int          XW   = 10,
    parameter int          YW   = 10,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [XW-1:0] width,
    input  logic [YW-1:0] height,
    input  logic [7:0]    colour,
    input  logic [7:0]    plane_mask,
    input  logic [1:0]    op,
    input  logic [AW-1:0] stride,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-3:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    import rfill_pkg::*;

    localparam int LANES = 4;

    typedef struct packed {
        rfill_state_e  st;
        logic          done;
        logic [AW-1:0] addr;
        logic [AW-1:0] row;
        logic [AW-1:0] stride;
        logic [XW-1:0] left;
        logic [XW-1:0] wid;
        logic [YW-1:0] rows;
        logic [7:0]    col;
        logic [7:0]    msk;
        logic [1:0]    op;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic          is_word;
    logic [2:0]    step;
    logic [3:0]    be;
    logic [AW-1:0] first_addr;
    logic [31:0]   new_word;

    rfill_chunk #(.XW(XW)) u_chunk (
        .addr_lo (ctx_q.addr[1:0]),
        .left    (ctx_q.left),
        .wid     (ctx_q.wid),
        .is_word (is_word),
        .step    (step),
        .be      (be)
    );

    rfill_lane_alu #(.LANES(LANES)) u_alu (
        .old_word (mem_rdata),
        .colour   (ctx_q.col),
        .msk      (ctx_q.msk),
        .op       (ctx_q.op),
        .new_word (new_word)
    );

    assign first_addr = BASE + AW'(dst_y) * stride + AW'(dst_x);

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (width == '0 || height == '0) begin
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.done   = 1'b0;
                        ctx_d.addr   = first_addr;
                        ctx_d.row    = first_addr;
                        ctx_d.stride = stride;
                        ctx_d.left   = width;
                        ctx_d.wid    = width;
                        ctx_d.rows   = height;
                        ctx_d.col    = colour;
                        ctx_d.msk    = plane_mask;
                        ctx_d.op     = op;
                        ctx_d.st     = needs_old(op, plane_mask) ? ST_READ : ST_WRITE;
                    end
                end
            end
            ST_READ: ctx_d.st = ST_WRITE;
            ST_WRITE: begin
                ctx_d.st = needs_old(ctx_q.op, ctx_q.msk) ? ST_READ : ST_WRITE;
                if (ctx_q.left == XW'(step)) begin
                    if (ctx_q.rows == YW'(1)) begin
                        ctx_d.st   = ST_IDLE;
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.row  = ctx_q.row + ctx_q.stride;
                        ctx_d.addr = ctx_q.row + ctx_q.stride;
                        ctx_d.left = ctx_q.wid;
                        ctx_d.rows = ctx_q.rows - YW'(1);
                    end
                end else begin
                    ctx_d.addr = ctx_q.addr + AW'(step);
                    ctx_d.left = ctx_q.left - XW'(step);
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.st   <= ST_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy      = (ctx_q.st != ST_IDLE);
    assign done      = ctx_q.done;
    assign mem_req   = busy;
    assign mem_we    = (ctx_q.st == ST_WRITE);
    assign mem_addr  = ctx_q.addr[AW-1:2];
    assign mem_be    = be;
    assign mem_wdata = new_word;

    // R2
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == 4'b1111) || $onehot(mem_be));

    // R3
    word_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 4'b1111) |-> (ctx_q.wid > XW'(3)));

    // R7
    blind_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctx_q.op == OP_SET && ctx_q.msk == 8'hFF) |-> mem_we);

    // R8
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_be)));

    // R9
    empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (width == '0 || height == '0)) |=> (done && !mem_req));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ctx_q.col) && $stable(ctx_q.stride) && $stable(ctx_q.op)));

endmodule

// File: tb/sim_rfill_engine.sv
`timescale 1ns/1ps
module sim_rfill_engine;
    localparam int AW = 12;
    localparam int XW = 6;
    localparam int YW = 4;
    localparam logic [AW-1:0] BASE = 12'd130;
    localparam int NBYTES = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [XW-1:0] dst_x = '0;
    logic [YW-1:0] dst_y = '0;
    logic [XW-1:0] width = '0;
    logic [YW-1:0] height = '0;
    logic [7:0] colour = '0;
    logic [7:0] plane_mask = '0;
    logic [1:0] op = '0;
    logic [AW-1:0] stride = '0;
    logic busy, done, mem_req, mem_we;
    logic [AW-3:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    rfill_engine #(.AW(AW), .XW(XW), .YW(YW), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height), .colour(colour), .plane_mask(plane_mask),
        .op(op), .stride(stride), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] ram [NBYTES/4];
    logic [7:0]  refm [NBYTES];
    int n_wr, n_rd, n_word, n_unpaired;
    logic last_rd = 1'b0;
    logic [AW-3:0] last_addr = '0;
    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) ram[mem_addr][8*k +: 8] = mem_wdata[8*k +: 8];
                n_wr++;
                if (mem_be == 4'b1111) n_word++;
                if (!last_rd || last_addr != mem_addr) n_unpaired++;
            end else begin
                mem_rdata <= ram[mem_addr];
                n_rd++;
            end
        end
        last_rd   = mem_req && !mem_we;
        last_addr = mem_addr;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'(a * 37 + seed * 13 + 11);
    endfunction

    task automatic run_op(input int x, input int y, input int w, input int h,
                          input logic [7:0] col, input logic [7:0] msk,
                          input logic [1:0] opc, input int strd, input int seed,
                          input bit poke);
        int ew, ewords, er, chunks, bad, first_bad, cyc;
        bit need;
        for (int a = 0; a < NBYTES; a++) begin
            refm[a] = pat(a, seed);
            ram[a/4][8*(a%4) +: 8] = pat(a, seed);
        end
        need = (opc != 2'b00) || (msk != 8'hFF);
        chunks = 0; ewords = 0;
        for (int r = 0; r < h; r++) begin
            int rs, head, rem;
            rs = int'(BASE) + (y + r) * strd + x;
            for (int i = 0; i < w; i++) begin
                logic [7:0] o, n;
                o = refm[rs + i];
                case (opc)
                    2'b00:   n = (col & msk) | (o & ~msk);
                    2'b01:   n = o ^ (col & msk);
                    default: n = ~o;
                endcase
                refm[rs + i] = n;
            end
            if (w <= 3) begin
                chunks += w;
            end else begin
                head = (4 - rs % 4) % 4;
                if (head > w) head = w;
                rem = w - head;
                chunks += head + rem / 4 + rem % 4;
                ewords += rem / 4;
            end
        end
        ew = chunks;
        er = need ? chunks : 0;
        @(negedge clk);
        n_wr = 0; n_rd = 0; n_word = 0; n_unpaired = 0;
        dst_x = XW'(x); dst_y = YW'(y); width = XW'(w); height = YW'(h);
        colour = col; plane_mask = msk; op = opc; stride = AW'(strd);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (w == 0 || h == 0) begin
            // R9: done on the accepting edge, idle, no accesses
            chk(done && !busy, "R9", "empty start done", int'(done), 1);
        end else begin
            chk(busy && !done, "R10", "done cleared by start", int'(done), 0);
            if (poke && (ew + er) >= 4) begin
                @(negedge clk);
                dst_x = '0; dst_y = '0; width = XW'(1); height = YW'(1);
                colour = ~col; plane_mask = 8'hFF; op = 2'b10; stride = AW'(1);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R10", "operation completes", cyc, 0);
        bad = 0; first_bad = -1;
        for (int a = 0; a < NBYTES; a++) begin
            if (ram[a/4][8*(a%4) +: 8] !== refm[a]) begin
                bad++;
                if (first_bad < 0) first_bad = a;
            end
        end
        // R1 R2 R4 R5 R6: whole-memory image matches the pixel model
        chk(bad == 0, "R1 R4 R5 R6", $sformatf("pixel image x%0d w%0d h%0d op%0d first bad byte %0d", x, w, h, opc, first_bad), bad, 0);
        // R2 R3: access split into head, words, tail
        chk(n_wr == ew, "R2", "write count", n_wr, ew);
        chk(n_word == ewords, "R3", "word write count", n_word, ewords);
        // R7 R8: reads only when the old pixel is needed, each paired
        chk(n_rd == er, need ? "R8" : "R7", "read count", n_rd, er);
        chk(n_unpaired == (need ? 0 : ew), "R8", "unpaired writes", n_unpaired, need ? 0 : ew);
        repeat (3) @(negedge clk);
        chk(done && !mem_req, "R10", "done held while idle", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R10", "reset state", int'(busy) + int'(done) + int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 4; v++) begin
            for (int x = 0; x < 5; x++) begin
                for (int w = 0; w < 10; w++) begin
                    for (int hi = 0; hi < 3; hi++) begin
                        int h, strd, y;
                        logic [7:0] msk;
                        logic [1:0] opc;
                        h = (hi == 0) ? 0 : (hi == 1 ? 1 : 3);
                        strd = (x + w) % 3 == 0 ? 64 : ((x + w) % 3 == 1 ? 67 : 97);
                        y = w % 3;
                        case (v)
                            0: begin opc = 2'b00; msk = 8'hFF; end
                            1: begin opc = 2'b00; msk = 8'hA5; end
                            2: begin opc = 2'b01; msk = 8'h3C; end
                            default: begin opc = (w % 2 == 0) ? 2'b10 : 2'b11; msk = 8'h0F; end
                        endcase
                        run_op(x, y, w, h, 8'(8'h5A + w * 17 + x), msk, opc, strd,
                               v * 100 + x * 10 + w, (w + x) % 2 == 1);
                    end
                end
            end
        end
        // R3: wide aligned rows with long bodies
        run_op(2, 4, 33, 2, 8'hC3, 8'hFF, 2'b00, 96, 7, 1'b0);
        run_op(3, 1, 21, 4, 8'h81, 8'hF0, 2'b01, 101, 9, 1'b1);
        // R6: invert ignores colour and mask entirely
        run_op(1, 2, 7, 2, 8'hFF, 8'h00, 2'b10, 70, 11, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule